// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Checker

This block sits at the issue stage of an in-order core that can start two instructions per cycle. In every cycle it receives the class codes of the two oldest decoded instructions, older first. From these codes and its own record of the shared units it decides how many of the two may start (none, the older alone, or both). It also reports which integer issue slot or slots each started instruction occupies. It records the busy state of the units that stay occupied after issue: the integer divider, the floating-point divide/square-root unit, and the floating-point add stage that a multiply-accumulate claims some cycles after it starts. It also records the second issue cycle of three- and four-register transfers.

Each input position works as a valid/ready stream. A non-empty class code means the position holds an instruction. `issue_cnt` is the ready answer for the cycle: a value of 1 accepts the older position, and 2 accepts both. The front end must keep presenting any instruction that was not accepted, shifted so the oldest stays in the older position. The decision is combinational on the present codes and the registered reservations, so back-pressure takes effect in the same cycle. Reservations change only at the clock edge that follows an accepted instruction.

Top module: `dual_issue_hazard`

## Requirements
- R1: Codes 1 to 23 are instructions. Code 0 and codes 24 to 31 mark an empty position. If the older position is empty, `issue_cnt` is 0. If only the younger position is empty, at most 1 is issued.
- R2: The younger instruction never issues unless the older one issues in the same cycle. `issue_cnt` is always 0, 1 or 2.
- R3: Slot masks use bit 0 for slot 0 and bit 1 for slot 1. Plain ALU (1), shifted ALU (2), single load (4), single store (5) and branch (12) may use either slot. In a pair the older takes slot 0 (01) and the younger slot 1 (10). The exception is a younger that is restricted to slot 0: then the older gets 10 and the younger 01.
- R4: At most one load/store instruction (codes 4 to 9) issues per cycle.
- R5: Multiply (3), load pair (6), store pair (7), multi load (8) and multi store (9) issue alone, with slot mask 11.
- R6: In the cycle after a multi load (8) or multi store (9) issues, nothing issues.
- R7: Unsigned divide (10), signed divide (11) and the floating-point classes 13 to 23 issue only from slot 0 (mask 01). Two of them never issue together.
- R8: At most one branch (12) issues per cycle.
- R9: After an unsigned divide issues in cycle t, no divide issues before cycle t+8. After a signed divide, none issues before t+9.
- R10: After a single-precision FP divide/sqrt (17) issues in cycle t, no FP divide/sqrt (17 or 18) issues before t+13. After a double-precision one (18), none issues before t+28.
- R11: A multiply-accumulate (16) issued in cycle t owns the FP add stage in cycle t+4. A FP ALU op (13) or FP constant (14) presented in that cycle stalls. It is free to issue in any other cycle.
- R12: A synchronous reset clears every reservation, so a divide may issue in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| older_cls | input | 5 | Class code of the older instruction (0 = empty) |
| younger_cls | input | 5 | Class code of the younger instruction (0 = empty) |
| issue_cnt | output | 2 | Number of instructions accepted this cycle |
| older_slots | output | 2 | Slot mask used by the older instruction (00 if not issued) |
| younger_slots | output | 2 | Slot mask used by the younger instruction (00 if not issued) |

## Verification
The pairing decision is tried with directed pairs that each isolate one conflict: two load/stores, two branches, two slot-0-only classes, a both-slot class in either position, and an empty or out-of-range code. These separate a wrong pairing rule from a wrong slot swap. Timed sequences repeat the same divide, FP divide or multiply-accumulate-then-FP-ALU every cycle. They show the exact first cycle in which the reservation releases, so an off-by-one hold length shows up as a count mismatch. A reset taken in the middle of a divider hold shows whether reservations clear. Long random runs over all codes, including empty ones, check the combined effect against a cycle-level reference model. That model keeps reservation end times rather than counters.

// File: rtl/dih_pkg.sv
package dih_pkg;
  localparam int CLS_W = 5;

  typedef enum logic [CLS_W-1:0] {
    CL_NONE   = 5'd0,
    CL_ALU    = 5'd1,
    CL_ALUSH  = 5'd2,
    CL_MUL    = 5'd3,
    CL_LD1    = 5'd4,
    CL_ST1    = 5'd5,
    CL_LD2    = 5'd6,
    CL_ST2    = 5'd7,
    CL_LDM    = 5'd8,
    CL_STM    = 5'd9,
    CL_UDIV   = 5'd10,
    CL_SDIV   = 5'd11,
    CL_BR     = 5'd12,
    CL_FALU   = 5'd13,
    CL_FCONST = 5'd14,
    CL_FMUL   = 5'd15,
    CL_FMAC   = 5'd16,
    CL_FDIVS  = 5'd17,
    CL_FDIVD  = 5'd18,
    CL_R2F    = 5'd19,
    CL_F2R    = 5'd20,
    CL_FFLAG  = 5'd21,
    CL_FLD    = 5'd22,
    CL_FST    = 5'd23
  } cls_e;

  typedef struct packed {
    logic valid;
    logic s0_only;
    logic both;
    logic ls;
    logic br;
    logic udiv;
    logic sdiv;
    logic fdivs;
    logic fdivd;
    logic fadd;
    logic mac;
    logic multi;
  } cls_attr_t;

  function automatic cls_attr_t decode_cls(logic [CLS_W-1:0] code);
    cls_attr_t a;
    a = '0;
    case (code)
      CL_ALU, CL_ALUSH: a.valid = 1'b1;
      CL_MUL: begin a.valid = 1'b1; a.both = 1'b1; end
      CL_LD1, CL_ST1: begin a.valid = 1'b1; a.ls = 1'b1; end
      CL_LD2, CL_ST2: begin a.valid = 1'b1; a.both = 1'b1; a.ls = 1'b1; end
      CL_LDM, CL_STM: begin
        a.valid = 1'b1; a.both = 1'b1; a.ls = 1'b1; a.multi = 1'b1;
      end
      CL_UDIV: begin a.valid = 1'b1; a.s0_only = 1'b1; a.udiv = 1'b1; end
      CL_SDIV: begin a.valid = 1'b1; a.s0_only = 1'b1; a.sdiv = 1'b1; end
      CL_BR: begin a.valid = 1'b1; a.br = 1'b1; end
      CL_FALU, CL_FCONST: begin a.valid = 1'b1; a.s0_only = 1'b1; a.fadd = 1'b1; end
      CL_FMAC: begin a.valid = 1'b1; a.s0_only = 1'b1; a.mac = 1'b1; end
      CL_FDIVS: begin a.valid = 1'b1; a.s0_only = 1'b1; a.fdivs = 1'b1; end
      CL_FDIVD: begin a.valid = 1'b1; a.s0_only = 1'b1; a.fdivd = 1'b1; end
      CL_FMUL, CL_R2F, CL_F2R, CL_FFLAG, CL_FLD, CL_FST: begin
        a.valid = 1'b1; a.s0_only = 1'b1;
      end
      default: a = '0;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/dih_class_decode.sv
module dih_class_decode
  import dih_pkg::*;
(
  input  logic [CLS_W-1:0] code_i,
  output cls_attr_t        attr_o
);
  always_comb attr_o = decode_cls(code_i);
endmodule

// File: rtl/dih_countdown.sv
module dih_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                  remain_q <= '0;
    else if (load)            remain_q <= load_val;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/dih_mac_window.sv
module dih_mac_window #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic claim_now
);
  logic [DELAY-1:0] pipe_q;

  generate
    if (DELAY == 1) begin : g_short
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= start;
      end
    end else begin : g_long
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[DELAY-2:0], start};
      end
    end
  endgenerate

  assign claim_now = pipe_q[DELAY-1];
endmodule

// File: rtl/dih_pair_arbiter.sv
module dih_pair_arbiter
  import dih_pkg::*;
(
  input  cls_attr_t  a_old,
  input  cls_attr_t  a_yng,
  input  logic       idiv_busy,
  input  logic       fdiv_busy,
  input  logic       fadd_busy,
  input  logic       multi_hold,
  output logic       old_go,
  output logic       yng_go,
  output logic [1:0] issue_cnt,
  output logic [1:0] old_slots,
  output logic [1:0] yng_slots
);
  function automatic logic units_free(cls_attr_t a);
    return a.valid
         & ~((a.udiv  | a.sdiv)  & idiv_busy)
         & ~((a.fdivs | a.fdivd) & fdiv_busy)
         & ~(a.fadd & fadd_busy);
  endfunction

  logic pair_ok;
  logic unused_fields;

  assign unused_fields = ^{a_old.mac, a_old.multi, a_yng.mac, a_yng.multi};

  always_comb begin
    old_go  = ~multi_hold & units_free(a_old);
    pair_ok = units_free(a_yng)
            & ~a_old.both & ~a_yng.both
            & ~(a_old.s0_only & a_yng.s0_only)
            & ~(a_old.ls & a_yng.ls)
            & ~(a_old.br & a_yng.br);
    yng_go  = old_go & pair_ok;

    issue_cnt = yng_go ? 2'd2 : (old_go ? 2'd1 : 2'd0);

    old_slots = 2'b00;
    yng_slots = 2'b00;
    if (old_go) begin
      if (a_old.both) begin
        old_slots = 2'b11;
      end else if (yng_go && a_yng.s0_only) begin
        old_slots = 2'b10;
        yng_slots = 2'b01;
      end else begin
        old_slots = 2'b01;
        if (yng_go) yng_slots = 2'b10;
      end
    end
  end
endmodule

// File: rtl/dual_issue_hazard.sv
module dual_issue_hazard
  import dih_pkg::*;
#(
  parameter int UDIV_HOLD  = 8,
  parameter int SDIV_HOLD  = 9,
  parameter int FDIVS_HOLD = 13,
  parameter int FDIVD_HOLD = 28,
  parameter int MAC_DELAY  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CLS_W-1:0] older_cls,
  input  logic [CLS_W-1:0] younger_cls,
  output logic [1:0]       issue_cnt,
  output logic [1:0]       older_slots,
  output logic [1:0]       younger_slots
);
  localparam int IDIV_MAX = (UDIV_HOLD > SDIV_HOLD) ? UDIV_HOLD : SDIV_HOLD;
  localparam int FDIV_MAX = (FDIVS_HOLD > FDIVD_HOLD) ? FDIVS_HOLD : FDIVD_HOLD;
  localparam int IDIV_W   = $clog2(IDIV_MAX);
  localparam int FDIV_W   = $clog2(FDIV_MAX);
  localparam int NPOS     = 2;

  logic [CLS_W-1:0] pos_cls [NPOS];
  cls_attr_t        attr    [NPOS];

  assign pos_cls[0] = older_cls;
  assign pos_cls[1] = younger_cls;

  generate
    for (genvar g = 0; g < NPOS; g++) begin : g_dec
      dih_class_decode u_dec (.code_i(pos_cls[g]), .attr_o(attr[g]));
    end
  endgenerate

  logic old_go, yng_go;
  logic idiv_busy, fdiv_busy, fadd_busy;
  logic multi_hold_q;

  dih_pair_arbiter u_arb (
    .a_old      (attr[0]),
    .a_yng      (attr[1]),
    .idiv_busy  (idiv_busy),
    .fdiv_busy  (fdiv_busy),
    .fadd_busy  (fadd_busy),
    .multi_hold (multi_hold_q),
    .old_go     (old_go),
    .yng_go     (yng_go),
    .issue_cnt  (issue_cnt),
    .old_slots  (older_slots),
    .yng_slots  (younger_slots)
  );

  logic st_udiv, st_sdiv, st_fdivs, st_fdivd, st_mac, st_multi;

  always_comb begin
    st_udiv  = (old_go & attr[0].udiv)  | (yng_go & attr[1].udiv);
    st_sdiv  = (old_go & attr[0].sdiv)  | (yng_go & attr[1].sdiv);
    st_fdivs = (old_go & attr[0].fdivs) | (yng_go & attr[1].fdivs);
    st_fdivd = (old_go & attr[0].fdivd) | (yng_go & attr[1].fdivd);
    st_mac   = (old_go & attr[0].mac)   | (yng_go & attr[1].mac);
    st_multi = (old_go & attr[0].multi) | (yng_go & attr[1].multi);
  end

  logic [IDIV_W-1:0] idiv_load;
  logic [FDIV_W-1:0] fdiv_load;

  assign idiv_load = st_sdiv  ? IDIV_W'(SDIV_HOLD - 1)  : IDIV_W'(UDIV_HOLD - 1);
  assign fdiv_load = st_fdivd ? FDIV_W'(FDIVD_HOLD - 1) : FDIV_W'(FDIVS_HOLD - 1);

  dih_countdown #(.W(IDIV_W)) u_idiv (
    .clk(clk), .rst(rst), .load(st_udiv | st_sdiv),
    .load_val(idiv_load), .busy(idiv_busy)
  );

  dih_countdown #(.W(FDIV_W)) u_fdiv (
    .clk(clk), .rst(rst), .load(st_fdivs | st_fdivd),
    .load_val(fdiv_load), .busy(fdiv_busy)
  );

  dih_mac_window #(.DELAY(MAC_DELAY)) u_mac (
    .clk(clk), .rst(rst), .start(st_mac), .claim_now(fadd_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) multi_hold_q <= 1'b0;
    else     multi_hold_q <= st_multi;
  end
endmodule

// File: rtl/dual_issue_hazard_chk.sv
module dual_issue_hazard_chk
  import dih_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CLS_W-1:0] older_cls,
  input logic [CLS_W-1:0] younger_cls,
  input logic [1:0]       issue_cnt,
  input logic [1:0]       older_slots,
  input logic [1:0]       younger_slots
);
  cls_attr_t ao, ay;
  logic old_iss, yng_iss, div_iss;

  always_comb begin
    ao      = decode_cls(older_cls);
    ay      = decode_cls(younger_cls);
    old_iss = (issue_cnt != 2'd0);
    yng_iss = (issue_cnt == 2'd2);
    div_iss = (old_iss & (ao.udiv | ao.sdiv)) | (yng_iss & (ay.udiv | ay.sdiv));
  end

  p_empty_old_r1: assert property (@(posedge clk) disable iff (rst)
    !ao.valid |-> issue_cnt == 2'd0);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    issue_cnt != 2'd3);

  p_slot_disjoint_r3: assert property (@(posedge clk) disable iff (rst)
    yng_iss |-> ((older_slots & younger_slots) == 2'b00) && older_slots != 2'b00 && younger_slots != 2'b00);

  p_ls_single_r4: assert property (@(posedge clk) disable iff (rst)
    yng_iss |-> !(ao.ls && ay.ls));

  p_both_alone_r5: assert property (@(posedge clk) disable iff (rst)
    (old_iss && ao.both) |-> issue_cnt == 2'd1 && older_slots == 2'b11);

  p_multi_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (old_iss && ao.multi) |=> issue_cnt == 2'd0);

  p_slot0_only_r7: assert property (@(posedge clk) disable iff (rst)
    (old_iss && ao.s0_only) |-> older_slots == 2'b01);

  p_branch_one_r8: assert property (@(posedge clk) disable iff (rst)
    yng_iss |-> !(ao.br && ay.br));

  p_div_gap_r9: assert property (@(posedge clk) disable iff (rst)
    div_iss |=> !div_iss);
endmodule

bind dual_issue_hazard dual_issue_hazard_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .older_cls     (older_cls),
  .younger_cls   (younger_cls),
  .issue_cnt     (issue_cnt),
  .older_slots   (older_slots),
  .younger_slots (younger_slots)
);

// File: tb/dual_issue_hazard_bench.sv
module dual_issue_hazard_bench;
  localparam int UDIV_T = 8;
  localparam int SDIV_T = 9;
  localparam int FDS_T  = 13;
  localparam int FDD_T  = 28;
  localparam int MAC_T  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] older_cls = '0;
  logic [4:0] younger_cls = '0;
  logic [1:0] issue_cnt, older_slots, younger_slots;

  always #5 clk = ~clk;

  dual_issue_hazard u_dual_issue_hazard (
    .clk(clk), .rst(rst),
    .older_cls(older_cls), .younger_cls(younger_cls),
    .issue_cnt(issue_cnt), .older_slots(older_slots), .younger_slots(younger_slots)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int cyc, hold_at, div_free, fdiv_free;
  bit addmap [8];

  function automatic bit m_valid(int c); return c >= 1 && c <= 23; endfunction
  function automatic bit m_both(int c);  return c == 3 || (c >= 6 && c <= 9); endfunction
  function automatic bit m_ls(int c);    return c >= 4 && c <= 9; endfunction
  function automatic bit m_s0(int c);    return c == 10 || c == 11 || (c >= 13 && c <= 23); endfunction
  function automatic bit m_br(int c);    return c == 12; endfunction

  function automatic bit m_ready(int c);
    if (!m_valid(c)) return 0;
    if ((c == 10 || c == 11) && cyc < div_free) return 0;
    if ((c == 17 || c == 18) && cyc < fdiv_free) return 0;
    if ((c == 13 || c == 14) && addmap[cyc % 8]) return 0;
    return 1;
  endfunction

  task automatic m_reset();
    cyc = 0; hold_at = -1; div_free = 0; fdiv_free = 0;
    for (int i = 0; i < 8; i++) addmap[i] = 0;
  endtask

  task automatic m_eval(input int o, input int y, output logic [1:0] ec,
                        output logic [1:0] eos, output logic [1:0] eys);
    ec = 0; eos = 0; eys = 0;
    if (cyc != hold_at && m_ready(o)) begin
      ec = 1;
      eos = m_both(o) ? 2'b11 : 2'b01;
      if (m_ready(y) && !m_both(o) && !m_both(y) && !(m_s0(o) && m_s0(y)) &&
          !(m_ls(o) && m_ls(y)) && !(m_br(o) && m_br(y))) begin
        ec = 2;
        if (m_s0(y)) begin eos = 2'b10; eys = 2'b01; end
        else eys = 2'b10;
      end
    end
  endtask

  task automatic m_take(input int c);
    if (c == 8 || c == 9) hold_at = cyc + 1;
    if (c == 10) div_free  = cyc + UDIV_T;
    if (c == 11) div_free  = cyc + SDIV_T;
    if (c == 17) fdiv_free = cyc + FDS_T;
    if (c == 18) fdiv_free = cyc + FDD_T;
    if (c == 16) addmap[(cyc + MAC_T) % 8] = 1;
  endtask

  task automatic m_commit(input int o, input int y, input logic [1:0] ec);
    addmap[cyc % 8] = 0;
    if (ec >= 1) m_take(o);
    if (ec == 2) m_take(y);
    cyc++;
  endtask

  task automatic step(input int o, input int y, input string tag);
    logic [1:0] ec, eos, eys;
    @(negedge clk);
    older_cls = 5'(o); younger_cls = 5'(y);
    #1;
    m_eval(o, y, ec, eos, eys);
    checks++;
    if (issue_cnt !== ec || older_slots !== eos || younger_slots !== eys) begin
      fails++;
      $display("FAIL %s: cls %0d/%0d got cnt=%0d slots=%b/%b expected cnt=%0d slots=%b/%b",
               tag, o, y, issue_cnt, older_slots, younger_slots, ec, eos, eys);
    end
    @(posedge clk);
    m_commit(o, y, ec);
  endtask

  task automatic do_reset();
    @(negedge clk);
    older_cls = '0; younger_cls = '0; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2: watchdog expired, got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    do_reset();

    step(1, 1, "R12");      // reset state: free pairing
    step(1, 2, "R3");
    step(1, 13, "R3");      // younger slot-0 only: swap
    step(12, 4, "R3");
    step(0, 1, "R1");
    step(26, 1, "R1");
    step(1, 0, "R1");
    step(1, 31, "R1");
    step(4, 5, "R4");
    step(5, 9, "R4");
    step(3, 1, "R5");
    step(1, 6, "R5");
    step(7, 12, "R5");
    step(12, 12, "R8");
    step(12, 1, "R8");
    step(13, 15, "R7");
    step(19, 1, "R7");
    step(8, 1, "R6");
    step(1, 1, "R6");
    step(1, 1, "R6");
    step(9, 0, "R6");
    step(12, 0, "R6");

    step(10, 1, "R9");
    for (int i = 0; i < 10; i++) step(10, 0, "R9");
    for (int i = 0; i < 11; i++) step(11, 1, "R9");
    for (int i = 0; i < 10; i++) step(1, 11, "R2");

    step(17, 0, "R10");
    for (int i = 0; i < 15; i++) step(17, 1, "R10");
    for (int i = 0; i < 30; i++) step(18, 0, "R10");
    for (int i = 0; i < 30; i++) step(17, 0, "R10");

    step(16, 1, "R11");
    step(1, 0, "R11");
    step(1, 0, "R11");
    step(13, 0, "R11");
    step(13, 1, "R11");
    step(14, 1, "R11");
    step(16, 0, "R11");
    step(1, 1, "R11");
    step(1, 1, "R11");
    step(1, 1, "R11");
    step(1, 14, "R11");
    step(1, 14, "R11");

    step(10, 0, "R12");
    step(1, 0, "R12");
    do_reset();
    step(10, 1, "R12");

    for (int i = 0; i < 3000; i++) begin
      int o, y;
      o = int'($urandom_range(0, 27));
      y = int'($urandom_range(0, 27));
      step(o, y, "R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule